// File: doc/BRIEF.md
# DRAM Bank Command Issue Engine

This block sits between a set of per-bank request slots and a DRAM command bus. In each clock cycle it chooses at most one command from ACTIVATE, PRECHARGE, READ and WRITE. Each bank slot holds at most one request, and the block keeps the open row and the open or idle state of every bank. A bank with a request for its open row gets column commands. A bank that has a different row open is precharged. An idle bank with a request is activated.

Timing is enforced by saturating down-counters at three levels: the whole channel, each bank group, and each bank. Each counter is loaded from a module parameter when the command it guards is issued. A timing value of T means the command it gates can issue no earlier than T cycles after the command that loaded it.

Banks are scanned round-robin from a priority index. The index moves past the chosen bank only when a row command (ACTIVATE or PRECHARGE) is issued. READ and WRITE commands are handed to a downstream data queue, and the block respects that queue's full flag.

Top module: `dram_cmd_issue`

## Requirements
- R1: At most one command appears per cycle on the command bus. `cmd_kind` is encoded as 0 = ACTIVATE, 1 = PRECHARGE, 2 = READ, 3 = WRITE. A command is only ever issued to a bank whose slot holds a request.
- R2: A READ issues only when all of the following hold:
  - the bank is open on the request's row;
  - at least T_RCD cycles have passed since that bank's ACTIVATE;
  - at least T_WTR cycles have passed since the last WRITE on the channel;
  - the column spacing of R4 is satisfied;
  - `dq_full` is low.
- R3: A WRITE follows the same rules as a READ, with two substitutions: it waits T_RCDWR cycles after ACTIVATE instead of T_RCD, and T_RTW cycles after the last READ on the channel instead of T_WTR.
- R4: Two column commands are at least T_CCD cycles apart anywhere on the channel. They are at least T_CCDL cycles apart when both target the same bank group, where the group is the bank index shifted right by GRP_SHIFT.
- R5: An ACTIVATE goes only to an idle bank, and only when all of the following hold:
  - at least T_RRD cycles have passed since the previous ACTIVATE on the channel;
  - at least T_RP cycles have passed since that bank's PRECHARGE;
  - at least T_RC cycles have passed since that bank's previous ACTIVATE.

  The ACTIVATE opens the request's row, and `cmd_row` carries that row.
- R6: A PRECHARGE goes only to an open bank whose request names a different row, and only when all of the following hold:
  - at least T_RAS cycles have passed since that bank's ACTIVATE;
  - at least T_WTP cycles have passed since its last WRITE;
  - at least BURST_LEN/DATA_RATIO cycles have passed since its last READ;
  - at least T_RTPL cycles have passed since the last READ in its group.

  The PRECHARGE leaves the bank idle.
- R7: Banks are scanned starting at the priority index and wrapping around. After an ACTIVATE or PRECHARGE to bank b, the index becomes b+1 modulo the bank count. READ and WRITE leave the index unchanged.
- R8: `req_ready` is high exactly when the slot of `req_bank` is empty. A request of L bytes receives ceil(L/ATOM_BYTES) column commands, and its slot is empty from the cycle after the last one.
- R9: After reset every bank is idle and every slot is empty, all counters are clear, and the priority index is 0. No command issues until a request is loaded.
- R10: While `dq_full` is high, no READ or WRITE issues, but ACTIVATE and PRECHARGE still do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The slot of `req_bank` is empty |
| req_bank | input | BW | Target bank of the offered request |
| req_row | input | ROW_W | Row of the offered request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LEN_W | Request length in bytes |
| dq_full | input | 1 | Downstream data queue cannot take a column command |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 2 | Command code (see R1) |
| cmd_bank | output | BW | Bank of the issued command |
| cmd_row | output | ROW_W | Row of the pending request of that bank |

## Verification
The hardest case to reach is two or more banks that become eligible in the same cycle while the priority index points above the lowest of them. Only that case separates rotating order from fixed order. The stimulus reaches it by issuing one ACTIVATE that holds off every other ACTIVATE for T_RRD cycles, and by loading lower- and higher-numbered bank slots during that window. Each turnaround limit (T_WTR, T_RTW, T_CCDL, T_RAS, T_RP) is made the binding limit in its own scenario, so that each issue cycle is checked exactly rather than as a lower bound.

// File: rtl/dci_pkg.sv
package dci_pkg;

    localparam int TCW = 8;

    typedef logic [TCW-1:0] tcnt_t;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_PRE = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } cmd_e;

    typedef enum logic {
        BK_IDLE = 1'b0,
        BK_OPEN = 1'b1
    } bank_st_e;

    // value loaded so that a span of t gives a gap of t cycles
    function automatic tcnt_t arm_val(int unsigned t);
        return (t == 0) ? '0 : tcnt_t'(t - 1);
    endfunction

    function automatic tcnt_t tick(tcnt_t c);
        return (c == '0) ? '0 : c - tcnt_t'(1);
    endfunction

endpackage

// File: rtl/dci_timer.sv
module dci_timer
    import dci_pkg::*;
#(
    parameter int unsigned SPAN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic busy
);
    tcnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (fire) cnt <= arm_val(SPAN);
        else           cnt <= tick(cnt);
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/dci_group.sv
module dci_group
    import dci_pkg::*;
#(
    parameter int unsigned T_CCDL = 4,
    parameter int unsigned T_RTPL = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic col_fire,
    input  logic rd_fire,
    output logic col_busy,
    output logic rtp_busy
);
    dci_timer #(.SPAN(T_CCDL)) u_ccdl (.clk(clk), .rst(rst), .fire(col_fire), .busy(col_busy));
    dci_timer #(.SPAN(T_RTPL)) u_rtpl (.clk(clk), .rst(rst), .fire(rd_fire),  .busy(rtp_busy));
endmodule

// File: rtl/dci_bank.sv
module dci_bank
    import dci_pkg::*;
#(
    parameter int          ROW_W   = 8,
    parameter int          LEN_W   = 8,
    parameter int unsigned ATOM    = 32,
    parameter int unsigned T_RCD   = 3,
    parameter int unsigned T_RCDWR = 2,
    parameter int unsigned T_RAS   = 8,
    parameter int unsigned T_RC    = 12,
    parameter int unsigned T_RP    = 5,
    parameter int unsigned T_WTP   = 5,
    parameter int unsigned T_RTP   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] ld_row,
    input  logic             ld_write,
    input  logic [LEN_W-1:0] ld_len,
    input  logic             col_rd_ok,
    input  logic             col_wr_ok,
    input  logic             act_ok,
    input  logic             grp_pre_ok,
    input  logic             grant,
    output logic             occupied,
    output logic             can_go,
    output cmd_e             go_kind,
    output logic [ROW_W-1:0] slot_row
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             wr;
        logic [LEN_W-1:0] len;
    } slot_t;

    localparam logic [LEN_W:0] ATOM_W = (LEN_W+1)'(ATOM);

    slot_t            slot;
    logic             valid;
    logic [LEN_W:0]   sent;
    bank_st_e         st;
    logic [ROW_W-1:0] open_row;

    logic rcd_busy, rcdwr_busy, ras_busy, rc_busy, rp_busy, wtp_busy, rtp_busy;
    logic can_rd, can_wr, can_act, can_pre;
    logic fire_act, fire_pre, fire_rd, fire_wr;
    logic [LEN_W:0] sent_nx;
    logic           col_done;
    logic           row_hit;

    assign row_hit = (st == BK_OPEN) && (open_row == slot.row);
    assign can_rd  = valid && !slot.wr && row_hit && !rcd_busy   && col_rd_ok;
    assign can_wr  = valid &&  slot.wr && row_hit && !rcdwr_busy && col_wr_ok;
    assign can_act = valid && (st == BK_IDLE) && !rp_busy && !rc_busy && act_ok;
    assign can_pre = valid && (st == BK_OPEN) && (open_row != slot.row)
                     && !ras_busy && !wtp_busy && !rtp_busy && grp_pre_ok;

    always_comb begin
        if (can_rd)       go_kind = CMD_RD;
        else if (can_wr)  go_kind = CMD_WR;
        else if (can_act) go_kind = CMD_ACT;
        else              go_kind = CMD_PRE;
    end

    assign can_go   = can_rd || can_wr || can_act || can_pre;
    assign occupied = valid;
    assign slot_row = slot.row;

    assign fire_act = grant && (go_kind == CMD_ACT);
    assign fire_pre = grant && (go_kind == CMD_PRE);
    assign fire_rd  = grant && (go_kind == CMD_RD);
    assign fire_wr  = grant && (go_kind == CMD_WR);

    assign sent_nx  = sent + ATOM_W;
    assign col_done = (sent_nx >= {1'b0, slot.len});

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            slot     <= '0;
            sent     <= '0;
            st       <= BK_IDLE;
            open_row <= '0;
        end else begin
            if (load) begin
                valid <= 1'b1;
                slot  <= '{row: ld_row, wr: ld_write, len: ld_len};
                sent  <= '0;
            end
            if (fire_act) begin
                st       <= BK_OPEN;
                open_row <= slot.row;
            end
            if (fire_pre) st <= BK_IDLE;
            if (fire_rd || fire_wr) begin
                if (col_done) begin
                    valid <= 1'b0;
                    sent  <= '0;
                end else begin
                    sent <= sent_nx;
                end
            end
        end
    end

    dci_timer #(.SPAN(T_RCD))   u_rcd   (.clk(clk), .rst(rst), .fire(fire_act), .busy(rcd_busy));
    dci_timer #(.SPAN(T_RCDWR)) u_rcdwr (.clk(clk), .rst(rst), .fire(fire_act), .busy(rcdwr_busy));
    dci_timer #(.SPAN(T_RAS))   u_ras   (.clk(clk), .rst(rst), .fire(fire_act), .busy(ras_busy));
    dci_timer #(.SPAN(T_RC))    u_rc    (.clk(clk), .rst(rst), .fire(fire_act), .busy(rc_busy));
    dci_timer #(.SPAN(T_RP))    u_rp    (.clk(clk), .rst(rst), .fire(fire_pre), .busy(rp_busy));
    dci_timer #(.SPAN(T_WTP))   u_wtp   (.clk(clk), .rst(rst), .fire(fire_wr),  .busy(wtp_busy));
    dci_timer #(.SPAN(T_RTP))   u_rtp   (.clk(clk), .rst(rst), .fire(fire_rd),  .busy(rtp_busy));

    // R6
    pre_then_no_col_chk: assert property (@(posedge clk) disable iff (rst)
        fire_pre |=> !(fire_rd || fire_wr));

    // R8
    load_only_empty_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !valid);

    generate
        if (T_RCD >= 2) begin : g_rcd_chk
            // R2
            act_then_no_rd_chk: assert property (@(posedge clk) disable iff (rst)
                fire_act |=> !fire_rd);
        end
    endgenerate
endmodule

// File: rtl/dram_cmd_issue.sv
module dram_cmd_issue
    import dci_pkg::*;
#(
    parameter int          NUM_BANKS  = 4,
    parameter int          GRP_SHIFT  = 1,
    parameter int          ROW_W      = 8,
    parameter int          LEN_W      = 8,
    parameter int unsigned ATOM_BYTES = 32,
    parameter int unsigned T_RRD      = 4,
    parameter int unsigned T_RCD      = 3,
    parameter int unsigned T_RCDWR    = 2,
    parameter int unsigned T_RAS      = 8,
    parameter int unsigned T_RC       = 12,
    parameter int unsigned T_RP       = 5,
    parameter int unsigned T_CCD      = 2,
    parameter int unsigned T_CCDL     = 4,
    parameter int unsigned T_RTW      = 5,
    parameter int unsigned T_WTR      = 6,
    parameter int unsigned T_WTP      = 5,
    parameter int unsigned T_RTPL     = 3,
    parameter int unsigned BURST_LEN  = 4,
    parameter int unsigned DATA_RATIO = 2,
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BW-1:0]    req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic             req_write,
    input  logic [LEN_W-1:0] req_len,
    input  logic             dq_full,
    output logic             cmd_valid,
    output logic [1:0]       cmd_kind,
    output logic [BW-1:0]    cmd_bank,
    output logic [ROW_W-1:0] cmd_row
);
    localparam int          NUM_GRPS = ((NUM_BANKS - 1) >> GRP_SHIFT) + 1;
    localparam int unsigned T_RTP    = BURST_LEN / DATA_RATIO;

    logic [NUM_BANKS-1:0] occupied, can_go, grant, load;
    logic [NUM_BANKS-1:0] col_rd_ok, col_wr_ok, grp_pre_ok;
    cmd_e                 kinds [NUM_BANKS];
    logic [ROW_W-1:0]     rows  [NUM_BANKS];

    logic [NUM_GRPS-1:0]  grp_col, grp_rd, ccdl_busy, rtpl_busy;
    logic                 ccd_busy, rrd_busy, rtw_busy, wtr_busy;

    logic                 pick_found;
    logic [BW-1:0]        pick_idx;
    logic [BW-1:0]        prio;
    cmd_e                 pick_kind;
    logic                 col_fire, rd_fire, wr_fire, act_fire, row_fire;

    // ---------------- request intake ----------------
    assign req_ready = !occupied[req_bank];

    // ---------------- per-bank slots ----------------
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam int G = b >> GRP_SHIFT;

            assign load[b]       = req_valid && req_ready && (req_bank == BW'(b));
            assign grant[b]      = pick_found && (pick_idx == BW'(b));
            assign col_rd_ok[b]  = !ccd_busy && !ccdl_busy[G] && !wtr_busy && !dq_full;
            assign col_wr_ok[b]  = !ccd_busy && !ccdl_busy[G] && !rtw_busy && !dq_full;
            assign grp_pre_ok[b] = !rtpl_busy[G];

            dci_bank #(
                .ROW_W(ROW_W), .LEN_W(LEN_W), .ATOM(ATOM_BYTES),
                .T_RCD(T_RCD), .T_RCDWR(T_RCDWR), .T_RAS(T_RAS), .T_RC(T_RC),
                .T_RP(T_RP), .T_WTP(T_WTP), .T_RTP(T_RTP)
            ) u_bank (
                .clk(clk), .rst(rst),
                .load(load[b]), .ld_row(req_row), .ld_write(req_write), .ld_len(req_len),
                .col_rd_ok(col_rd_ok[b]), .col_wr_ok(col_wr_ok[b]),
                .act_ok(!rrd_busy), .grp_pre_ok(grp_pre_ok[b]),
                .grant(grant[b]),
                .occupied(occupied[b]), .can_go(can_go[b]),
                .go_kind(kinds[b]), .slot_row(rows[b])
            );
        end

        for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
            dci_group #(.T_CCDL(T_CCDL), .T_RTPL(T_RTPL)) u_grp (
                .clk(clk), .rst(rst),
                .col_fire(grp_col[g]), .rd_fire(grp_rd[g]),
                .col_busy(ccdl_busy[g]), .rtp_busy(rtpl_busy[g])
            );
        end
    endgenerate

    // ---------------- rotating scan ----------------
    always_comb begin
        pick_found = 1'b0;
        pick_idx   = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin : scan
            int j;
            j = int'(prio) + i;
            if (j >= NUM_BANKS) j = j - NUM_BANKS;
            if (!pick_found && can_go[j]) begin
                pick_found = 1'b1;
                pick_idx   = BW'(j);
            end
        end
    end

    assign pick_kind = kinds[pick_idx];
    assign rd_fire   = pick_found && (pick_kind == CMD_RD);
    assign wr_fire   = pick_found && (pick_kind == CMD_WR);
    assign act_fire  = pick_found && (pick_kind == CMD_ACT);
    assign col_fire  = rd_fire || wr_fire;
    assign row_fire  = pick_found && !col_fire;

    always_comb begin
        for (int g = 0; g < NUM_GRPS; g++) begin
            grp_col[g] = col_fire && ((int'(pick_idx) >> GRP_SHIFT) == g);
            grp_rd[g]  = rd_fire  && ((int'(pick_idx) >> GRP_SHIFT) == g);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio <= '0;
        end else if (row_fire) begin
            prio <= (int'(pick_idx) == NUM_BANKS - 1) ? '0 : pick_idx + BW'(1);
        end
    end

    // ---------------- channel timers ----------------
    dci_timer #(.SPAN(T_CCD)) u_ccd (.clk(clk), .rst(rst), .fire(col_fire), .busy(ccd_busy));
    dci_timer #(.SPAN(T_RRD)) u_rrd (.clk(clk), .rst(rst), .fire(act_fire), .busy(rrd_busy));
    dci_timer #(.SPAN(T_RTW)) u_rtw (.clk(clk), .rst(rst), .fire(rd_fire),  .busy(rtw_busy));
    dci_timer #(.SPAN(T_WTR)) u_wtr (.clk(clk), .rst(rst), .fire(wr_fire),  .busy(wtr_busy));

    // ---------------- command bus ----------------
    assign cmd_valid = pick_found;
    assign cmd_kind  = pick_kind;
    assign cmd_bank  = pick_idx;
    assign cmd_row   = rows[pick_idx];

    // R10
    dq_full_col_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && dq_full) |-> (cmd_kind == CMD_ACT || cmd_kind == CMD_PRE));

    // R7
    prio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        col_fire |=> $stable(prio));

    // R1
    cmd_on_loaded_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> occupied[cmd_bank]);

    generate
        if (T_CCD >= 2) begin : g_ccd_chk
            // R4
            col_gap_chk: assert property (@(posedge clk) disable iff (rst)
                col_fire |=> !col_fire);
        end
        if (T_RRD >= 2) begin : g_rrd_chk
            // R5
            act_gap_chk: assert property (@(posedge clk) disable iff (rst)
                act_fire |=> !act_fire);
        end
    endgenerate
endmodule

// File: tb/dram_cmd_issue_bench.sv
module dram_cmd_issue_bench;
    localparam int NB = 4;
    localparam int BW = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_bank = '0;
    logic [7:0] req_row = '0;
    logic       req_write = 1'b0;
    logic [7:0] req_len = '0;
    logic       dq_full = 1'b0;
    logic       cmd_valid;
    logic [1:0] cmd_kind;
    logic [1:0] cmd_bank;
    logic [7:0] cmd_row;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int       lg_n = 0;
    int       lg_cyc  [32];
    int       lg_bank [32];
    int       lg_kind [32];
    int       lg_row  [32];

    always #5 clk = ~clk;

    dram_cmd_issue #(
        .NUM_BANKS(NB), .GRP_SHIFT(1), .ROW_W(8), .LEN_W(8), .ATOM_BYTES(32),
        .T_RRD(4), .T_RCD(3), .T_RCDWR(2), .T_RAS(8), .T_RC(12), .T_RP(5),
        .T_CCD(2), .T_CCDL(4), .T_RTW(5), .T_WTR(6), .T_WTP(5), .T_RTPL(3),
        .BURST_LEN(4), .DATA_RATIO(2)
    ) u_dram_cmd_issue (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_row(req_row), .req_write(req_write), .req_len(req_len),
        .dq_full(dq_full),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_row(cmd_row)
    );

    // command monitor, samples mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cmd_valid && lg_n < 32) begin
                lg_cyc[lg_n]  = cyc;
                lg_bank[lg_n] = int'(cmd_bank);
                lg_kind[lg_n] = int'(cmd_kind);
                lg_row[lg_n]  = int'(cmd_row);
                lg_n++;
            end
            cyc++;
        end
    end

    task automatic check(bit ok, string tag, string what, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic expect_cmd(int idx, int k, int b, int rel, string tag);
        int gk, gb, gt;
        gk = (idx < lg_n) ? lg_kind[idx] : -1;
        gb = (idx < lg_n) ? lg_bank[idx] : -1;
        gt = (idx < lg_n) ? lg_cyc[idx] - lg_cyc[0] : -1;
        checks++;
        if (gk != k || gb != b || gt != rel) begin
            errors++;
            $display("FAIL %s: cmd %0d got kind=%0d bank=%0d t=%0d expected kind=%0d bank=%0d t=%0d",
                     tag, idx, gk, gb, gt, k, b, rel);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 1'b0;
        dq_full = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        lg_n = 0;
    endtask

    task automatic send(int b, int row, bit wr, int len);
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_bank  = BW'(b);
        req_row   = 8'(row);
        req_write = wr;
        req_len   = 8'(len);
        #1;
        while (!req_ready) begin
            @(posedge clk);
            #2;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // R9: reset state
    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        check(cmd_valid == 1'b0, "R9", "cmd_valid in reset", int'(cmd_valid), 0);
        do_reset();
        for (int b = 0; b < NB; b++) begin
            req_bank = BW'(b);
            #1;
            check(req_ready == 1'b1, "R9", "ready of empty slot", int'(req_ready), 1);
        end
        settle(6);
        check(lg_n == 0, "R9", "commands with no request", lg_n, 0);
    endtask

    // R4/R8: channel vs group column spacing, multi-atom request
    task automatic t_col_spacing();
        do_reset();
        send(0, 5, 1'b0, 64);
        req_bank = 2'd0;
        #1;
        check(req_ready == 1'b0, "R8", "ready while slot busy", int'(req_ready), 0);
        send(2, 7, 1'b0, 32);
        settle(20);
        expect_cmd(0, 0, 0, 0, "R5");
        check(lg_row[0] == 5, "R5", "activated row", lg_row[0], 5);
        expect_cmd(1, 2, 0, 3, "R2");
        expect_cmd(2, 0, 2, 4, "R5");
        expect_cmd(3, 2, 0, 7, "R4");
        expect_cmd(4, 2, 2, 9, "R4");
        check(lg_n == 5, "R8", "command count", lg_n, 5);
        req_bank = 2'd0;
        #1;
        check(req_ready == 1'b1, "R8", "slot freed after two atoms", int'(req_ready), 1);
    endtask

    // R6/R5: row conflict precharge then re-activate
    task automatic t_row_conflict();
        do_reset();
        send(0, 5, 1'b0, 32);
        send(0, 9, 1'b0, 32);
        settle(25);
        expect_cmd(0, 0, 0, 0, "R5");
        expect_cmd(1, 2, 0, 3, "R2");
        expect_cmd(2, 1, 0, 8, "R6");
        expect_cmd(3, 0, 0, 13, "R5");
        check(lg_row[3] == 9, "R5", "new row", lg_row[3], 9);
        expect_cmd(4, 2, 0, 16, "R2");
        check(lg_n == 5, "R1", "command count", lg_n, 5);
    endtask

    // R7: rotating priority picks bank 3 over bank 0
    task automatic t_rotation();
        do_reset();
        send(2, 1, 1'b0, 32);
        send(0, 2, 1'b0, 32);
        send(3, 3, 1'b0, 32);
        settle(20);
        expect_cmd(0, 0, 2, 0, "R7");
        expect_cmd(1, 2, 2, 3, "R7");
        expect_cmd(2, 0, 3, 4, "R7");
        expect_cmd(3, 2, 3, 7, "R7");
        expect_cmd(4, 0, 0, 8, "R7");
        expect_cmd(5, 2, 0, 11, "R7");
        check(lg_n == 6, "R1", "command count", lg_n, 6);
    endtask

    // R2: write-to-read turnaround binds
    task automatic t_wtr();
        do_reset();
        send(0, 1, 1'b1, 32);
        send(1, 1, 1'b0, 32);
        settle(20);
        expect_cmd(0, 0, 0, 0, "R5");
        expect_cmd(1, 3, 0, 2, "R3");
        expect_cmd(2, 0, 1, 4, "R5");
        expect_cmd(3, 2, 1, 8, "R2");
    endtask

    // R3: read-to-write turnaround binds
    task automatic t_rtw();
        do_reset();
        send(0, 1, 1'b0, 32);
        send(1, 1, 1'b1, 32);
        settle(20);
        expect_cmd(0, 0, 0, 0, "R5");
        expect_cmd(1, 2, 0, 3, "R2");
        expect_cmd(2, 0, 1, 4, "R5");
        expect_cmd(3, 3, 1, 8, "R3");
    endtask

    // R10: full data queue holds column commands only
    task automatic t_dq_full();
        do_reset();
        dq_full = 1'b1;
        send(0, 4, 1'b0, 32);
        repeat (10) @(posedge clk);
        check(lg_n == 1, "R10", "commands while full", lg_n, 1);
        expect_cmd(0, 0, 0, 0, "R10");
        #1;
        dq_full = 1'b0;
        settle(5);
        expect_cmd(1, 2, 0, 10, "R10");
    endtask

    initial begin
        t_reset();
        t_col_spacing();
        t_row_conflict();
        t_rotation();
        t_wtr();
        t_rtw();
        t_dq_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, got 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule